// File: doc/BRIEF.md
# Pipelined Priority Bus Arbiter

This block decides which of several bus masters owns the address path of a shared high-bandwidth on-chip bus. A master holds its request, a 2-bit priority, a read/write flag, an address and a qualifier word, and optionally a lock. In an idle cycle the arbiter picks one eligible master, grants it, and on the next cycle presents the latched address, qualifiers, direction and master index to the slaves with a one-cycle address-valid strobe. The grant stays up until the slave returns an address acknowledge. If no acknowledge comes within the timeout window, the master receives an error pulse instead.

After an acknowledged address phase, the transfer's data tenure is tracked per direction. Read and write tenures are counted separately, so one read and one write can run together. Each direction accepts one further address phase ahead of its active data tenure. When that slot is taken, requests in that direction wait and the other direction keeps flowing. A lock that is asserted when a locked grant is acknowledged reserves the bus for that master until it drops the lock.

Back-pressure rules: a slave stalls the address phase by withholding its acknowledge. A master must keep its request and fields stable until it sees its done or error pulse, and it removes the request in the next cycle. Data completion inputs act as single-cycle done strobes and have no ready counterpart.

Top module: `pipelined_bus_arbiter`

## Requirements
- R1: After reset, and after any reset applied in mid-operation, no grant or strobe is active, both data tenures are idle, the bus is unlocked, and the round-robin pointer restarts so that master 0 wins the first tie.
- R2: At most one grant is active at a time. A grant goes only to a requesting, eligible master, one cycle after an idle cycle in which that master was eligible.
- R3: Priority 3 is the highest and 0 the lowest. The highest eligible priority always wins.
- R4: Among eligible masters of equal top priority, the first one found scanning upward (with wrap-around) from the master granted last wins.
- R5: In the first cycle of a grant, `s_avalid` is high for exactly one cycle, and `s_addr`, `s_qual`, `s_rnw` and `s_master` carry the winner's values sampled in the arbitration cycle.
- R6: A grant stays unchanged until `s_aack` is seen. In that cycle the owner's `m_done` bit is high, and the grant drops on the next cycle.
- R7: If `s_aack` is not seen in 16 grant cycles, the owner's `m_err` bit is high in the 16th cycle, the grant drops, and no data tenure is opened.
- R8: An acknowledged read (`m_rnw`=1) opens a read tenure and an acknowledged write (`m_rnw`=0) opens a write tenure. `rd_busy`/`wr_busy` stay high until `s_rd_done`/`s_wr_done` have closed every open tenure of that direction. A done strobe with nothing open has no effect.
- R9: A direction holds at most two open tenures, one active and one pipelined, shown by `rd_full`/`wr_full`. While a direction is full, no request in that direction is granted, but the other direction still is.
- R10: When a locked request is acknowledged, `bus_locked` rises and only that master is eligible until the cycle after its `m_lock` input is seen low.
- R11: A locked request that times out does not lock the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | N_MASTERS | Per-master request |
| m_prio | input | 2*N_MASTERS | Per-master priority, 2 bits each, 3 highest |
| m_lock | input | N_MASTERS | Per-master lock request |
| m_rnw | input | N_MASTERS | Per-master direction, 1 = read |
| m_addr | input | N_MASTERS*ADDR_W | Per-master address |
| m_qual | input | N_MASTERS*QUAL_W | Per-master transfer qualifiers |
| m_gnt | output | N_MASTERS | One-hot grant during the address phase |
| m_done | output | N_MASTERS | Address acknowledged pulse to the owner |
| m_err | output | N_MASTERS | Address timeout pulse to the owner |
| s_avalid | output | 1 | One-cycle address-valid strobe |
| s_addr | output | ADDR_W | Granted address |
| s_rnw | output | 1 | Granted direction |
| s_qual | output | QUAL_W | Granted qualifiers |
| s_master | output | $clog2(N_MASTERS) | Index of the granted master |
| s_aack | input | 1 | Slave address acknowledge |
| s_rd_done | input | 1 | Read data tenure complete strobe |
| s_wr_done | input | 1 | Write data tenure complete strobe |
| rd_busy | output | 1 | A read data tenure is open |
| wr_busy | output | 1 | A write data tenure is open |
| rd_full | output | 1 | The read pipeline slot is taken |
| wr_full | output | 1 | The write pipeline slot is taken |
| bus_locked | output | 1 | The bus is reserved for the lock owner |

## Verification
All four masters request together at one priority to show the rotation order. Mixed priorities separate the priority rule from the rotation rule. A silent slave exercises the timeout, and it also shows that a locked request that times out leaves the bus unlocked. Holding a lock across a second request shows exclusivity, and a reset in mid-operation shows that both the lock and the pointer are cleared. Long random runs then vary priorities, directions, acknowledge delays, done strobes and lock toggles. This fills the pipeline slots so that the blocking of one direction can be told apart from the freedom of the other.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
  typedef enum logic {ARB_IDLE, ARB_ADDR} arb_state_e;
  typedef logic [1:0] prio_t;
  localparam int PRIO_LEVELS = 4;
endpackage

// File: rtl/arb_winner_pick.sv
module arb_winner_pick #(
  parameter int N_MASTERS = 4,
  parameter int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic [N_MASTERS-1:0]   elig,
  input  logic [2*N_MASTERS-1:0] prio,
  input  logic [IW-1:0]          last_id,
  output logic                   any,
  output logic [IW-1:0]          win_id
);
  import busarb_pkg::*;

  logic [N_MASTERS-1:0] lvl_mask [PRIO_LEVELS];
  logic [N_MASTERS-1:0] top_mask;

  // one mask per priority level
  for (genvar gl = 0; gl < PRIO_LEVELS; gl++) begin : g_lvl
    for (genvar gi = 0; gi < N_MASTERS; gi++) begin : g_m
      assign lvl_mask[gl][gi] = elig[gi] && (prio[2*gi +: 2] == prio_t'(gl));
    end
  end

  // the highest level that has any candidate
  always_comb begin
    top_mask = '0;
    for (int l = PRIO_LEVELS - 1; l >= 0; l--) begin
      if (top_mask == '0) top_mask = lvl_mask[l];
    end
  end

  // rotate from the master after the last one granted
  always_comb begin
    logic found;
    int   idx;
    found  = 1'b0;
    win_id = '0;
    for (int k = 0; k < N_MASTERS; k++) begin
      idx = int'(last_id) + 1 + k;
      if (idx >= N_MASTERS) idx = idx - N_MASTERS;
      if (!found && top_mask[idx]) begin
        found  = 1'b1;
        win_id = IW'(idx);
      end
    end
    any = |top_mask;
  end
endmodule

// File: rtl/data_tenure_track.sv
module data_tenure_track #(
  parameter int PIPE_DEPTH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic open_evt,
  input  logic close_evt,
  output logic busy,
  output logic full
);
  localparam int CAP = PIPE_DEPTH + 1;
  localparam int CW  = $clog2(CAP + 1);

  logic [CW-1:0] open_cnt;
  logic          close_ok;
  logic          open_ok;

  assign close_ok = close_evt && (open_cnt != '0);
  assign open_ok  = open_evt && (open_cnt != CW'(CAP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_cnt <= '0;
    end else begin
      case ({open_ok, close_ok})
        2'b10:   open_cnt <= open_cnt + 1'b1;
        2'b01:   open_cnt <= open_cnt - 1'b1;
        default: open_cnt <= open_cnt;
      endcase
    end
  end

  assign busy = (open_cnt != '0);
  assign full = (open_cnt == CW'(CAP));
endmodule

// File: rtl/bus_lock_keeper.sv
module bus_lock_keeper #(
  parameter int N_MASTERS = 4,
  parameter int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic [IW-1:0]        take_id,
  input  logic [N_MASTERS-1:0] hold,
  output logic                 locked,
  output logic [IW-1:0]        owner
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b0;
      owner  <= '0;
    end else if (take) begin
      locked <= 1'b1;
      owner  <= take_id;
    end else if (locked && !hold[owner]) begin
      locked <= 1'b0;
    end
  end
endmodule

// File: rtl/addr_tenure_ctrl.sv
module addr_tenure_ctrl #(
  parameter int N_MASTERS   = 4,
  parameter int ADDR_W      = 32,
  parameter int QUAL_W      = 4,
  parameter int TIMEOUT_CYC = 16,
  parameter int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_ok,
  input  logic [IW-1:0]        start_id,
  input  logic [ADDR_W-1:0]    start_addr,
  input  logic [QUAL_W-1:0]    start_qual,
  input  logic                 start_rnw,
  input  logic                 slv_ack,
  output logic [N_MASTERS-1:0] gnt_o,
  output logic [IW-1:0]        owner_o,
  output logic [IW-1:0]        last_id_o,
  output logic                 active_o,
  output logic                 avalid_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [QUAL_W-1:0]    qual_o,
  output logic                 rnw_o,
  output logic                 ack_evt_o,
  output logic                 tmo_evt_o
);
  import busarb_pkg::*;

  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  arb_state_e    state;
  logic [TW-1:0] wait_cnt;
  logic          at_limit;

  assign at_limit = (wait_cnt == TW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ARB_IDLE;
      owner_o   <= '0;
      last_id_o <= IW'(N_MASTERS - 1);
      avalid_o  <= 1'b0;
      addr_o    <= '0;
      qual_o    <= '0;
      rnw_o     <= 1'b0;
      wait_cnt  <= '0;
    end else begin
      case (state)
        ARB_IDLE: begin
          avalid_o <= 1'b0;
          if (start_ok) begin
            state     <= ARB_ADDR;
            owner_o   <= start_id;
            last_id_o <= start_id;
            addr_o    <= start_addr;
            qual_o    <= start_qual;
            rnw_o     <= start_rnw;
            avalid_o  <= 1'b1;
            wait_cnt  <= '0;
          end
        end
        ARB_ADDR: begin
          avalid_o <= 1'b0;
          if (slv_ack || at_limit) begin
            state <= ARB_IDLE;
          end else begin
            wait_cnt <= wait_cnt + 1'b1;
          end
        end
        default: state <= ARB_IDLE;
      endcase
    end
  end

  assign active_o  = (state == ARB_ADDR);
  assign ack_evt_o = active_o && slv_ack;
  assign tmo_evt_o = active_o && !slv_ack && at_limit;

  for (genvar gi = 0; gi < N_MASTERS; gi++) begin : g_gnt
    assign gnt_o[gi] = active_o && (owner_o == IW'(gi));
  end
endmodule

// File: rtl/pipelined_bus_arbiter.sv
module pipelined_bus_arbiter #(
  parameter int N_MASTERS   = 4,
  parameter int ADDR_W      = 32,
  parameter int QUAL_W      = 4,
  parameter int TIMEOUT_CYC = 16,
  parameter int PIPE_DEPTH  = 1,
  localparam int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_MASTERS-1:0]        m_req,
  input  logic [2*N_MASTERS-1:0]      m_prio,
  input  logic [N_MASTERS-1:0]        m_lock,
  input  logic [N_MASTERS-1:0]        m_rnw,
  input  logic [N_MASTERS*ADDR_W-1:0] m_addr,
  input  logic [N_MASTERS*QUAL_W-1:0] m_qual,
  output logic [N_MASTERS-1:0]        m_gnt,
  output logic [N_MASTERS-1:0]        m_done,
  output logic [N_MASTERS-1:0]        m_err,
  output logic                        s_avalid,
  output logic [ADDR_W-1:0]           s_addr,
  output logic                        s_rnw,
  output logic [QUAL_W-1:0]           s_qual,
  output logic [IW-1:0]               s_master,
  input  logic                        s_aack,
  input  logic                        s_rd_done,
  input  logic                        s_wr_done,
  output logic                        rd_busy,
  output logic                        wr_busy,
  output logic                        rd_full,
  output logic                        wr_full,
  output logic                        bus_locked
);
  localparam int DIR_RD = 0;
  localparam int DIR_WR = 1;

  logic [N_MASTERS-1:0] elig;
  logic                 pick_any;
  logic [IW-1:0]        pick_id;
  logic [IW-1:0]        last_id;
  logic [IW-1:0]        owner;
  logic [IW-1:0]        lock_owner;
  logic                 active;
  logic                 ack_evt;
  logic                 tmo_evt;
  logic [ADDR_W-1:0]    pick_addr;
  logic [QUAL_W-1:0]    pick_qual;
  logic                 pick_rnw;
  logic [1:0]           dir_busy;
  logic [1:0]           dir_full;
  logic [1:0]           dir_close;

  // eligibility: requesting, not blocked by a foreign lock, direction slot free
  for (genvar gi = 0; gi < N_MASTERS; gi++) begin : g_elig
    logic lock_ok;
    logic slot_ok;
    assign lock_ok  = !bus_locked || (lock_owner == IW'(gi));
    assign slot_ok  = m_rnw[gi] ? !dir_full[DIR_RD] : !dir_full[DIR_WR];
    assign elig[gi] = m_req[gi] && lock_ok && slot_ok;
  end

  arb_winner_pick #(
    .N_MASTERS(N_MASTERS),
    .IW       (IW)
  ) u_pick (
    .elig   (elig),
    .prio   (m_prio),
    .last_id(last_id),
    .any    (pick_any),
    .win_id (pick_id)
  );

  // fields of the winner
  always_comb begin
    pick_addr = '0;
    pick_qual = '0;
    pick_rnw  = 1'b0;
    for (int i = 0; i < N_MASTERS; i++) begin
      if (pick_id == IW'(i)) begin
        pick_addr = m_addr[i*ADDR_W +: ADDR_W];
        pick_qual = m_qual[i*QUAL_W +: QUAL_W];
        pick_rnw  = m_rnw[i];
      end
    end
  end

  addr_tenure_ctrl #(
    .N_MASTERS  (N_MASTERS),
    .ADDR_W     (ADDR_W),
    .QUAL_W     (QUAL_W),
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .IW         (IW)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ok  (pick_any),
    .start_id  (pick_id),
    .start_addr(pick_addr),
    .start_qual(pick_qual),
    .start_rnw (pick_rnw),
    .slv_ack   (s_aack),
    .gnt_o     (m_gnt),
    .owner_o   (owner),
    .last_id_o (last_id),
    .active_o  (active),
    .avalid_o  (s_avalid),
    .addr_o    (s_addr),
    .qual_o    (s_qual),
    .rnw_o     (s_rnw),
    .ack_evt_o (ack_evt),
    .tmo_evt_o (tmo_evt)
  );

  assign s_master = owner;
  assign m_done   = m_gnt & {N_MASTERS{ack_evt}};
  assign m_err    = m_gnt & {N_MASTERS{tmo_evt}};

  // per-direction data tenure tracking
  assign dir_close[DIR_RD] = s_rd_done;
  assign dir_close[DIR_WR] = s_wr_done;

  for (genvar gd = 0; gd < 2; gd++) begin : g_dir
    logic open_evt;
    assign open_evt = ack_evt && (s_rnw == (gd == DIR_RD));
    data_tenure_track #(
      .PIPE_DEPTH(PIPE_DEPTH)
    ) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_evt (open_evt),
      .close_evt(dir_close[gd]),
      .busy     (dir_busy[gd]),
      .full     (dir_full[gd])
    );
  end

  assign rd_busy = dir_busy[DIR_RD];
  assign wr_busy = dir_busy[DIR_WR];
  assign rd_full = dir_full[DIR_RD];
  assign wr_full = dir_full[DIR_WR];

  bus_lock_keeper #(
    .N_MASTERS(N_MASTERS),
    .IW       (IW)
  ) u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (ack_evt && m_lock[owner]),
    .take_id(owner),
    .hold   (m_lock),
    .locked (bus_locked),
    .owner  (lock_owner)
  );

  logic unused_ok;
  assign unused_ok = active;
endmodule

// File: rtl/busarb_checker.sv
module busarb_checker #(
  parameter int N_MASTERS   = 4,
  parameter int TIMEOUT_CYC = 16,
  parameter int IW = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_MASTERS-1:0] m_req,
  input logic [N_MASTERS-1:0] m_gnt,
  input logic [N_MASTERS-1:0] m_err,
  input logic                 s_avalid,
  input logic                 s_rnw,
  input logic                 s_aack,
  input logic                 rd_busy,
  input logic                 wr_busy,
  input logic                 rd_full,
  input logic                 wr_full,
  input logic                 bus_locked,
  input logic [IW-1:0]        lock_owner
);
  localparam int TW = $clog2(TIMEOUT_CYC + 2);
  logic [TW-1:0] held_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) held_cnt <= '0;
    else if (|m_gnt) held_cnt <= held_cnt + 1'b1;
    else held_cnt <= '0;
  end

  assert_gnt_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(m_gnt));

  assert_gnt_to_requester_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|m_gnt) |-> (|(m_gnt & m_req)));

  assert_strobe_on_new_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|m_gnt) |-> s_avalid);

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_avalid |=> !s_avalid);

  assert_gnt_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|m_gnt) && !s_aack && !(|m_err)) |=> $stable(m_gnt));

  assert_wait_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|m_gnt) |-> (held_cnt < TW'(TIMEOUT_CYC)));

  assert_rd_full_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_full |-> rd_busy);

  assert_wr_full_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_full |-> wr_busy);

  assert_no_read_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_full |=> !(s_avalid && s_rnw));

  assert_no_write_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_full |=> !(s_avalid && !s_rnw));

  assert_lock_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_locked && (|m_gnt)) |-> m_gnt[lock_owner]);
endmodule

bind pipelined_bus_arbiter busarb_checker #(
  .N_MASTERS  (N_MASTERS),
  .TIMEOUT_CYC(TIMEOUT_CYC)
) u_busarb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .m_req     (m_req),
  .m_gnt     (m_gnt),
  .m_err     (m_err),
  .s_avalid  (s_avalid),
  .s_rnw     (s_rnw),
  .s_aack    (s_aack),
  .rd_busy   (rd_busy),
  .wr_busy   (wr_busy),
  .rd_full   (rd_full),
  .wr_full   (wr_full),
  .bus_locked(bus_locked),
  .lock_owner(lock_owner)
);

// File: tb/pipelined_bus_arbiter_tb.sv
module pipelined_bus_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 32;
  localparam int QW = 4;
  localparam int TO = 16;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N-1:0]  req, lk, rnw;
  logic [1:0]    pr [N];
  logic [AW-1:0] ad [N];
  logic [QW-1:0] ql [N];
  logic          aack, rdd, wrd;

  logic [2*N-1:0]  prio_f;
  logic [N*AW-1:0] addr_f;
  logic [N*QW-1:0] qual_f;
  always_comb begin
    for (int i = 0; i < N; i++) begin
      prio_f[2*i +: 2]   = pr[i];
      addr_f[i*AW +: AW] = ad[i];
      qual_f[i*QW +: QW] = ql[i];
    end
  end

  logic [N-1:0]  m_gnt, m_done, m_err;
  logic          s_avalid, s_rnw, rd_busy, wr_busy, rd_full, wr_full, bus_locked;
  logic [AW-1:0] s_addr;
  logic [QW-1:0] s_qual;
  logic [IW-1:0] s_master;

  pipelined_bus_arbiter #(
    .N_MASTERS(N), .ADDR_W(AW), .QUAL_W(QW), .TIMEOUT_CYC(TO), .PIPE_DEPTH(1)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .m_req(req), .m_prio(prio_f), .m_lock(lk),
    .m_rnw(rnw), .m_addr(addr_f), .m_qual(qual_f), .m_gnt(m_gnt),
    .m_done(m_done), .m_err(m_err), .s_avalid(s_avalid), .s_addr(s_addr),
    .s_rnw(s_rnw), .s_qual(s_qual), .s_master(s_master), .s_aack(aack),
    .s_rd_done(rdd), .s_wr_done(wrd), .rd_busy(rd_busy), .wr_busy(wr_busy),
    .rd_full(rd_full), .wr_full(wr_full), .bus_locked(bus_locked)
  );

  // expected state, built from the requirements
  bit            e_addr, e_first, e_lkd, mute;
  int            e_own, e_cnt, e_rr, e_lko, e_rdn, e_wrn;
  logic [AW-1:0] l_addr;
  logic [QW-1:0] l_qual;
  logic          l_rnw;
  logic [N-1:0]  fin;

  int total = 0, bad = 0, errs_seen = 0, nord = 0, cyc = 0;
  int ord [16];
  int ack_mode = 0, drain_mode = 0;
  bit auto_req = 0, ended = 0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic bit elig(input int i);
    return req[i] && (!e_lkd || i == e_lko) && (rnw[i] ? (e_rdn < 2) : (e_wrn < 2));
  endfunction

  function automatic int pick();
    int best, bestp;
    best = -1; bestp = -1;
    for (int k = 0; k < N; k++) begin
      int i;
      i = (e_rr + 1 + k) % N;
      if (elig(i) && int'(pr[i]) > bestp) begin best = i; bestp = int'(pr[i]); end
    end
    return best;
  endfunction

  task automatic model_reset();
    e_addr = 0; e_first = 0; e_lkd = 0; e_own = 0; e_cnt = 0;
    e_rr = N - 1; e_lko = 0; e_rdn = 0; e_wrn = 0; mute = 0;
  endtask

  task automatic step();
    logic [N-1:0] eg;
    bit tmo, nl;
    int nr, nw, w;
    #1;
    eg = '0;
    if (e_addr) eg[e_own] = 1'b1;
    chk(m_gnt == eg, "R2 R3 R4 grant", m_gnt, eg);
    chk(s_avalid == e_first, "R5 strobe", s_avalid, e_first);
    if (e_first) begin
      chk(s_addr == l_addr, "R5 address", s_addr, l_addr);
      chk({s_rnw, s_qual, s_master} == {l_rnw, l_qual, IW'(e_own)}, "R5 fields",
          {s_rnw, s_qual, s_master}, {l_rnw, l_qual, IW'(e_own)});
    end
    tmo = e_addr && !aack && (e_cnt == TO - 1);
    chk(m_done == ((e_addr && aack) ? eg : '0), "R6 done", m_done, (e_addr && aack) ? eg : '0);
    chk(m_err == (tmo ? eg : '0), "R7 timeout", m_err, tmo ? eg : '0);
    chk({rd_busy, rd_full, wr_busy, wr_full} == {e_rdn > 0, e_rdn == 2, e_wrn > 0, e_wrn == 2},
        "R8 R9 data tenure", {rd_busy, rd_full, wr_busy, wr_full},
        {e_rdn > 0, e_rdn == 2, e_wrn > 0, e_wrn == 2});
    chk(bus_locked == e_lkd, "R10 R11 lock", bus_locked, e_lkd);
    if (s_avalid && nord < 16) begin ord[nord] = int'(s_master); nord++; end
    if (|m_err) errs_seen++;
    fin = (e_addr && (aack || tmo)) ? eg : '0;
    // next expected state
    nr = e_rdn; nw = e_wrn;
    if (rdd && nr > 0) nr--;
    if (wrd && nw > 0) nw--;
    nl = e_lkd;
    if (e_lkd && !lk[e_lko]) nl = 0;
    e_first = 0;
    if (!e_addr) begin
      w = pick();
      if (w >= 0) begin
        e_addr = 1; e_own = w; e_cnt = 0; e_rr = w; e_first = 1;
        l_addr = ad[w]; l_qual = ql[w]; l_rnw = rnw[w];
        mute = ($urandom % 8) == 0;
      end
    end else if (aack) begin
      e_addr = 0;
      if (rnw[e_own]) nr++; else nw++;
      if (lk[e_own]) begin nl = 1; e_lko = e_own; end
    end else if (tmo) begin
      e_addr = 0;
    end else begin
      e_cnt++;
    end
    e_rdn = nr; e_wrn = nw; e_lkd = nl;
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < N; i++) if (fin[i]) req[i] = 1'b0;
  endtask

  task automatic drive();
    if (auto_req) begin
      for (int i = 0; i < N; i++) begin
        if (!req[i] && ($urandom % 3) == 0) begin
          req[i] = 1'b1; pr[i] = 2'($urandom); rnw[i] = 1'($urandom);
          ad[i] = $urandom; ql[i] = QW'($urandom);
        end
      end
      if (($urandom % 24) == 0) begin
        int j;
        j = $urandom % N;
        lk[j] = ~lk[j];
      end
    end
    case (ack_mode)
      1: aack = e_addr;
      2: aack = 1'b0;
      default: aack = e_addr && !mute && (($urandom % 3) == 0);
    endcase
    case (drain_mode)
      1: begin rdd = 1'b0; wrd = 1'b0; end
      2: begin rdd = 1'b1; wrd = 1'b1; end
      default: begin rdd = ($urandom % 4) == 0; wrd = ($urandom % 4) == 0; end
    endcase
  endtask

  task automatic run(input int n);
    for (int c = 0; c < n; c++) begin drive(); step(); end
  endtask

  task automatic set_m(input int i, input logic [1:0] p, input logic r, input logic l);
    req[i] = 1'b1; pr[i] = p; rnw[i] = r; lk[i] = l;
    ad[i] = 32'h1000_0000 + 32'(i); ql[i] = QW'(i + 5);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req = '0; lk = '0; rnw = '0; aack = 0; rdd = 0; wrd = 0;
    for (int i = 0; i < N; i++) begin pr[i] = '0; ad[i] = '0; ql[i] = '0; end
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    #1;
    chk(m_gnt == '0, "R1 grant after reset", m_gnt, 0);
    chk({s_avalid, rd_busy, wr_busy, bus_locked} == 4'b0, "R1 status after reset",
        {s_avalid, rd_busy, wr_busy, bus_locked}, 0);

    // equal priority: rotation from master 0
    ack_mode = 1; drain_mode = 1; nord = 0;
    for (int i = 0; i < N; i++) set_m(i, 2'd1, 1'(i % 2 == 0), 1'b0);
    run(12);
    chk(nord == 4, "R4 grant count", nord, 4);
    chk({ord[0], ord[1], ord[2], ord[3]} == {32'd0, 32'd1, 32'd2, 32'd3}, "R4 tie order",
        {ord[0][7:0], ord[1][7:0], ord[2][7:0], ord[3][7:0]}, 32'h00010203);
    chk(rd_full && wr_full, "R9 both slots full", {rd_full, wr_full}, 2'b11);
    drain_mode = 2; run(3);

    // mixed priority
    nord = 0;
    set_m(0, 2'd0, 1'b0, 1'b0); set_m(1, 2'd2, 1'b0, 1'b0);
    set_m(2, 2'd3, 1'b0, 1'b0); set_m(3, 2'd1, 1'b0, 1'b0);
    run(12);
    chk({ord[0], ord[1], ord[2], ord[3]} == {32'd2, 32'd1, 32'd3, 32'd0}, "R3 priority order",
        {ord[0][7:0], ord[1][7:0], ord[2][7:0], ord[3][7:0]}, 32'h02010300);

    // silent slave with a locked request
    ack_mode = 2; errs_seen = 0; nord = 0;
    set_m(1, 2'd2, 1'b1, 1'b1);
    run(20);
    chk(errs_seen == 1, "R7 single error", errs_seen, 1);
    chk(!bus_locked, "R11 no lock after timeout", bus_locked, 0);
    lk = '0;

    // lock exclusivity
    ack_mode = 1; nord = 0;
    set_m(0, 2'd0, 1'b1, 1'b1);
    run(4);
    chk(bus_locked, "R10 lock taken", bus_locked, 1);
    set_m(0, 2'd0, 1'b0, 1'b1); set_m(1, 2'd3, 1'b0, 1'b0); set_m(3, 2'd3, 1'b0, 1'b0);
    for (int c = 0; c < 12; c++) begin
      if (nord == 2) lk[0] = 1'b0;
      drive(); step();
    end
    chk({ord[0], ord[1], ord[2], ord[3]} == {32'd0, 32'd0, 32'd1, 32'd3}, "R10 locked order",
        {ord[0][7:0], ord[1][7:0], ord[2][7:0], ord[3][7:0]}, 32'h00000103);

    // reset in mid-operation clears lock and pointer
    set_m(2, 2'd1, 1'b1, 1'b1);
    run(3);
    do_reset();
    #1;
    chk({m_gnt, bus_locked, rd_busy, wr_busy} == '0, "R1 mid-run reset",
        {m_gnt, bus_locked, rd_busy, wr_busy}, 0);
    @(negedge clk);
    nord = 0;
    for (int i = 0; i < N; i++) set_m(i, 2'd2, 1'b0, 1'b0);
    run(4);
    chk(ord[0] == 0, "R1 pointer restart", ord[0], 0);
    run(10);

    // random traffic
    ack_mode = 0; drain_mode = 0; auto_req = 1;
    run(4000);
    auto_req = 0; ack_mode = 1; drain_mode = 2; lk = '0;
    run(80);

    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule